// File: doc/BRIEF.md
# Host Transmit Endpoint Control and Status

This block holds the 16-bit control and status word of one host-side transmit endpoint, together with the state logic around it. Software reads and writes the word through a plain register port. Software also loads packet bytes into the endpoint FIFO, and the block counts those bytes. A transaction engine reports the outcome of each attempt with single-cycle pulses. The block answers these pulses by updating the packet-ready flag, the data toggle and three sticky fault bits. It also issues FIFO flush requests and raises the endpoint interrupt.

The FIFO storage, token and packet generation, the DMA engine and frame timing all live outside the block. The word only stores the mode bits that steer the DMA engine. The `tx_go` output tells the transaction engine that a committed packet may be sent now. `setup_token` tells it to use a SETUP token instead of an OUT token for that packet.

Top module: `usb_htx_ctrl`

## Requirements
- R1: After reset, every bit of `reg_rdata` is 0, and `irq`, `flush_req`, `setup_token` and `tx_go` are 0.
- R2: The read word is {15 auto-commit, 14 reserved, 13 direction, 12 DMA request enable, 11 forced completion, 10 DMA mode, 9 toggle write enable, 8 toggle, 7 NAK halt, 6 toggle clear, 5 stall seen, 4 setup, 3 flush, 2 no-handshake error, 1 FIFO holds a packet, 0 packet ready}. Bits 14, 9, 6 and 3 always read 0. Bits 15, 13, 12, 11 and 10 read back the last value written.
- R3: A write changes the toggle (bit 8) only when bit 9 is 1 in the same write. Otherwise the written toggle value is ignored.
- R4: A write with bit 6 set, or with bit 4 set, clears the toggle. A write that sets bits 4 and 0 together commits the packet with `setup_token` at 1 until the packet leaves.
- R5: With bit 15 set, the packet-ready flag sets itself on the byte load that brings the byte count up to `max_pkt_size`. With bit 15 clear, only a software write of bit 0 commits the packet. Bytes offered while a packet is ready are not counted.
- R6: An ACK while a packet is ready clears packet-ready and inverts the toggle.
- R7: A write with bit 3 set flushes the packet only if packet-ready is 1. It then clears packet-ready and pulses `flush_req`. Otherwise it has no effect.
- R8: The third consecutive no-handshake pulse for one packet sets the error bit and drops the packet, for bulk (`xfer_type`=2) and interrupt (`xfer_type`=3) endpoints only. Control (0) and isochronous (1) endpoints never set the error bit.
- R9: Software clears the error, stall and NAK-halt bits by writing 0 to them. Writing 1 to them leaves them unchanged.
- R10: `irq` is a one-cycle pulse, gated by `irq_en`. It fires when packet-ready clears and when the error, stall or NAK-halt bit goes from 0 to 1.
- R11: A STALL while a packet is ready sets the stall bit, clears packet-ready and pulses `flush_req`.
- R12: A NAK-limit pulse sets the NAK-halt bit only on bulk endpoints (`xfer_type`=2). While that bit is set, `tx_go` is 0.
- R13: With bit 11 set, a no-handshake pulse completes the packet as if it were acknowledged: packet-ready clears and the toggle inverts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current register word |
| fifo_load | input | 1 | One byte loaded into the FIFO this cycle |
| max_pkt_size | input | MAXP_W | Maximum packet size in bytes |
| xfer_type | input | 2 | 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| irq_en | input | 1 | Interrupt enable |
| ev_ack | input | 1 | ACK received pulse |
| ev_nak_limit | input | 1 | NAK limit exceeded pulse |
| ev_stall | input | 1 | STALL received pulse |
| ev_no_hs | input | 1 | Attempt ended with no handshake |
| tx_go | output | 1 | A committed packet may be sent |
| setup_token | output | 1 | Send the packet with a SETUP token |
| flush_req | output | 1 | FIFO flush request pulse |
| irq | output | 1 | Endpoint interrupt pulse |

## Verification
Packet commitment is tried three ways: auto-commit on the byte count, a manual write, and a manual write together with the setup bit. This separates the byte counter path from the software path. The no-handshake pulse is applied in bulk, isochronous and forced-completion modes. Bulk shows that the strike count stops at three, isochronous shows that the error bit stays clear, and forced completion shows that the pulse acts like an ACK. A flush is sent once with no packet ready and once with a packet ready, and the NAK limit is sent once in bulk and once in interrupt mode. Each of these pairs separates the condition that gates the action from the action itself.

// File: rtl/usb_htx_pkg.sv
package usb_htx_pkg;
  localparam int unsigned B_AUTO   = 15;
  localparam int unsigned B_DIR    = 13;
  localparam int unsigned B_DMAEN  = 12;
  localparam int unsigned B_FRC    = 11;
  localparam int unsigned B_DMAMD  = 10;
  localparam int unsigned B_TOGWE  = 9;
  localparam int unsigned B_TOG    = 8;
  localparam int unsigned B_NAKTO  = 7;
  localparam int unsigned B_TOGCLR = 6;
  localparam int unsigned B_STALL  = 5;
  localparam int unsigned B_SETUP  = 4;
  localparam int unsigned B_FLUSH  = 3;
  localparam int unsigned B_ERR    = 2;
  localparam int unsigned B_RDY    = 0;

  typedef enum logic [1:0] {
    XF_CTRL = 2'd0,
    XF_ISO  = 2'd1,
    XF_BULK = 2'd2,
    XF_INTR = 2'd3
  } xfer_e;
endpackage

// File: rtl/usb_htx_bytecnt.sv
module usb_htx_bytecnt #(
  parameter int unsigned MAXP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clr,
  input  logic              autoset,
  input  logic [MAXP_W-1:0] maxp,
  output logic              auto_hit
);
  logic [MAXP_W-1:0] cnt_q, cnt_d;
  logic [MAXP_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc  = cnt_q + 1'b1;
    auto_hit = load && autoset && (cnt_inc == maxp);
    cnt_d    = cnt_q;
    if (clr || auto_hit) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || load) begin
      cnt_q <= cnt_d;
    end
  end

  AST_HIT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    auto_hit |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/usb_htx_strike.sv
module usb_htx_strike #(
  parameter int unsigned MAX_TRIES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic attempt,
  input  logic clr,
  output logic hit
);
  localparam int unsigned CW = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_TRIES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    hit   = attempt && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (clr || hit) begin
      cnt_d = '0;
    end else if (attempt) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || attempt) begin
      cnt_q <= cnt_d;
    end
  end

  AST_STRIKE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R8
endmodule

// File: rtl/usb_htx_ctrl.sv
module usb_htx_ctrl
  import usb_htx_pkg::*;
#(
  parameter int unsigned MAXP_W    = 11,
  parameter int unsigned MAX_TRIES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              fifo_load,
  input  logic [MAXP_W-1:0] max_pkt_size,
  input  logic [1:0]        xfer_type,
  input  logic              irq_en,
  input  logic              ev_ack,
  input  logic              ev_nak_limit,
  input  logic              ev_stall,
  input  logic              ev_no_hs,
  output logic              tx_go,
  output logic              setup_token,
  output logic              flush_req,
  output logic              irq
);
  logic auto_q, dir_q, dmaen_q, frc_q, dmamd_q;
  logic tog_q, nakto_q, stall_q, setup_q, err_q, rdy_q, irq_q, flush_q;
  logic auto_d, dir_d, dmaen_d, frc_d, dmamd_d;
  logic tog_d, nakto_d, stall_d, setup_d, err_d, rdy_d, irq_d, flush_d;

  logic is_bulk, is_bulk_like;
  logic ack_ok, frc_done, strike_att, strike_hit, stall_ok, nak_ok;
  logic cpu_flush, cpu_set, auto_hit, byte_load, byte_clr, strike_clr;

  assign is_bulk      = (xfer_e'(xfer_type) == XF_BULK);
  assign is_bulk_like = is_bulk || (xfer_e'(xfer_type) == XF_INTR);
  assign ack_ok       = rdy_q && ev_ack;
  assign frc_done     = rdy_q && frc_q && ev_no_hs;
  assign strike_att   = rdy_q && !frc_q && ev_no_hs && is_bulk_like;
  assign stall_ok     = rdy_q && ev_stall;
  assign nak_ok       = rdy_q && ev_nak_limit && is_bulk;
  assign cpu_flush    = reg_wr && reg_wdata[B_FLUSH] && rdy_q;
  assign cpu_set      = reg_wr && reg_wdata[B_RDY] && !rdy_q;
  assign byte_load    = fifo_load && !rdy_q;
  assign byte_clr     = cpu_set || cpu_flush || stall_ok;
  assign strike_clr   = cpu_set || auto_hit || ack_ok || frc_done || cpu_flush || stall_ok;

  usb_htx_bytecnt #(.MAXP_W(MAXP_W)) u_bytecnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (byte_load),
    .clr      (byte_clr),
    .autoset  (auto_q),
    .maxp     (max_pkt_size),
    .auto_hit (auto_hit)
  );

  usb_htx_strike #(.MAX_TRIES(MAX_TRIES)) u_strike (
    .clk     (clk),
    .rst_n   (rst_n),
    .attempt (strike_att),
    .clr     (strike_clr),
    .hit     (strike_hit)
  );

  always_comb begin
    auto_d  = auto_q;
    dir_d   = dir_q;
    dmaen_d = dmaen_q;
    frc_d   = frc_q;
    dmamd_d = dmamd_q;
    tog_d   = tog_q;
    nakto_d = nakto_q;
    stall_d = stall_q;
    setup_d = setup_q;
    err_d   = err_q;
    rdy_d   = rdy_q;

    if (reg_wr) begin
      auto_d  = reg_wdata[B_AUTO];
      dir_d   = reg_wdata[B_DIR];
      dmaen_d = reg_wdata[B_DMAEN];
      frc_d   = reg_wdata[B_FRC];
      dmamd_d = reg_wdata[B_DMAMD];
      if (reg_wdata[B_TOGWE]) tog_d = reg_wdata[B_TOG];
      if (reg_wdata[B_TOGCLR] || reg_wdata[B_SETUP]) tog_d = 1'b0;
      if (!reg_wdata[B_NAKTO]) nakto_d = 1'b0;
      if (!reg_wdata[B_STALL]) stall_d = 1'b0;
      if (!reg_wdata[B_ERR])   err_d   = 1'b0;
    end

    if (cpu_set) begin
      rdy_d   = 1'b1;
      setup_d = reg_wdata[B_SETUP];
    end
    if (auto_hit) begin
      rdy_d   = 1'b1;
      setup_d = 1'b0;
    end

    if (ack_ok || frc_done) begin
      rdy_d   = 1'b0;
      setup_d = 1'b0;
      tog_d   = ~tog_q;
    end
    if (cpu_flush) begin
      rdy_d   = 1'b0;
      setup_d = 1'b0;
    end
    if (strike_hit) begin
      err_d   = 1'b1;
      rdy_d   = 1'b0;
      setup_d = 1'b0;
    end
    if (stall_ok) begin
      stall_d = 1'b1;
      rdy_d   = 1'b0;
      setup_d = 1'b0;
    end
    if (nak_ok) nakto_d = 1'b1;

    flush_d = cpu_flush || stall_ok;
    irq_d   = irq_en && ((rdy_q && !rdy_d) || (err_d && !err_q) ||
                         (stall_d && !stall_q) || (nakto_d && !nakto_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q  <= 1'b0;
      dir_q   <= 1'b0;
      dmaen_q <= 1'b0;
      frc_q   <= 1'b0;
      dmamd_q <= 1'b0;
      tog_q   <= 1'b0;
      nakto_q <= 1'b0;
      stall_q <= 1'b0;
      setup_q <= 1'b0;
      err_q   <= 1'b0;
      rdy_q   <= 1'b0;
      irq_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      auto_q  <= auto_d;
      dir_q   <= dir_d;
      dmaen_q <= dmaen_d;
      frc_q   <= frc_d;
      dmamd_q <= dmamd_d;
      tog_q   <= tog_d;
      nakto_q <= nakto_d;
      stall_q <= stall_d;
      setup_q <= setup_d;
      err_q   <= err_d;
      rdy_q   <= rdy_d;
      irq_q   <= irq_d;
      flush_q <= flush_d;
    end
  end

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[B_AUTO]  = auto_q;
    reg_rdata[B_DIR]   = dir_q;
    reg_rdata[B_DMAEN] = dmaen_q;
    reg_rdata[B_FRC]   = frc_q;
    reg_rdata[B_DMAMD] = dmamd_q;
    reg_rdata[B_TOG]   = tog_q;
    reg_rdata[B_NAKTO] = nakto_q;
    reg_rdata[B_STALL] = stall_q;
    reg_rdata[B_SETUP] = setup_q;
    reg_rdata[B_ERR]   = err_q;
    reg_rdata[1]       = rdy_q;
    reg_rdata[B_RDY]   = rdy_q;
  end

  assign tx_go       = rdy_q && !nakto_q;
  assign setup_token = setup_q;
  assign flush_req   = flush_q;
  assign irq         = irq_q;

  AST_FLUSH_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(rdy_q)); // R7
  AST_ACK_FLIPS_TOG: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && ev_ack) |=> (tog_q != $past(tog_q)) && !rdy_q); // R6
  AST_STALL_DROPS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && ev_stall) |=> !rdy_q && stall_q && flush_req); // R11
  AST_AUTO_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    auto_hit |=> rdy_q); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en)); // R10
  AST_NAKTO_BULK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nakto_q) |-> ($past(xfer_type) == 2'd2)); // R12
endmodule

// File: tb/usb_htx_ctrl_tb.sv
module usb_htx_ctrl_tb_top;
  localparam int unsigned MAXP_W = 11;

  typedef struct {
    logic [19:0] exp;
    string       tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;
  logic              fifo_load = 1'b0;
  logic [MAXP_W-1:0] max_pkt_size = 11'd4;
  logic [1:0]        xfer_type = 2'd2;
  logic              irq_en = 1'b1;
  logic              ev_ack = 1'b0;
  logic              ev_nak_limit = 1'b0;
  logic              ev_stall = 1'b0;
  logic              ev_no_hs = 1'b0;
  logic              tx_go, setup_token, flush_req, irq;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  usb_htx_ctrl #(.MAXP_W(MAXP_W), .MAX_TRIES(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fifo_load(fifo_load), .max_pkt_size(max_pkt_size),
    .xfer_type(xfer_type), .irq_en(irq_en), .ev_ack(ev_ack),
    .ev_nak_limit(ev_nak_limit), .ev_stall(ev_stall), .ev_no_hs(ev_no_hs),
    .tx_go(tx_go), .setup_token(setup_token), .flush_req(flush_req), .irq(irq)
  );

  // Monitor: compares {irq, flush_req, setup_token, tx_go, reg_rdata}
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [19:0] act;
      it  = sb_q.pop_front();
      act = {irq, flush_req, setup_token, tx_go, reg_rdata};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got %05h expected %05h", it.tag, act, it.exp);
      end
    end
  end

  // Driver: one cycle of stimulus, then queue the expected outputs
  task automatic step(input logic w, input logic [15:0] d, input logic ld,
                      input logic a, input logic n, input logic s, input logic h,
                      input logic [3:0] flags, input logic [15:0] rd, input string tag);
    @(negedge clk);
    reg_wr = w; reg_wdata = d; fifo_load = ld;
    ev_ack = a; ev_nak_limit = n; ev_stall = s; ev_no_hs = h;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; fifo_load = 1'b0;
    ev_ack = 1'b0; ev_nak_limit = 1'b0; ev_stall = 1'b0; ev_no_hs = 1'b0;
    sb_q.push_back('{exp: {flags, rd}, tag: tag});
  endtask

  task automatic wr(input logic [15:0] d, input logic [3:0] f, input logic [15:0] rd, input string tag);
    step(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, f, rd, tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    sb_q.push_back('{exp: 20'h0, tag: "R1 reset state"});

    wr(16'hF400, 4'b0000, 16'hB400, "R2 mode bits stored, reserved reads 0");
    wr(16'hB500, 4'b0000, 16'hB400, "R3 toggle ignored without enable");
    wr(16'hB700, 4'b0000, 16'hB500, "R3 toggle written with enable");
    wr(16'hB440, 4'b0000, 16'hB400, "R4 toggle clear");
    for (int i = 0; i < 3; i++)
      step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 16'hB400, "R5 short load no commit");
    step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 16'hB403, "R5 auto-commit at max size");
    step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1000, 16'hB500, "R6 R10 ack flips toggle and interrupts");

    wr(16'h3400, 4'b0000, 16'h3500, "R2 auto-commit off");
    for (int i = 0; i < 4; i++)
      step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 16'h3500, "R5 no auto-commit when off");
    wr(16'h3401, 4'b0001, 16'h3503, "R5 manual commit");

    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0001, 16'h3503, "R8 first miss");
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0001, 16'h3503, "R8 second miss");
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1000, 16'h3504, "R8 third miss sets error");
    wr(16'h3400, 4'b0000, 16'h3500, "R9 error cleared by 0");
    wr(16'h3404, 4'b0000, 16'h3500, "R9 error not set by software");

    wr(16'h3408, 4'b0000, 16'h3500, "R7 flush ignored when not ready");
    wr(16'h3401, 4'b0001, 16'h3503, "R7 commit before flush");
    wr(16'h3408, 4'b1100, 16'h3500, "R7 flush acts when ready");

    wr(16'h3411, 4'b0011, 16'h3413, "R4 setup commit clears toggle");
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1100, 16'h3420, "R11 stall drops packet");
    wr(16'h3400, 4'b0000, 16'h3400, "R9 stall cleared by 0");

    wr(16'h3401, 4'b0001, 16'h3403, "R12 commit");
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1000, 16'h3483, "R12 NAK limit halts bulk");
    wr(16'h3401, 4'b0001, 16'h3403, "R9 NAK halt cleared by 0");
    xfer_type = 2'd3;
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0001, 16'h3403, "R12 NAK limit ignored for interrupt");
    xfer_type = 2'd1;
    for (int i = 0; i < 3; i++)
      step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0001, 16'h3403, "R8 no error for isochronous");

    wr(16'h3C01, 4'b0001, 16'h3C03, "R13 forced completion mode");
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1000, 16'h3D00, "R13 miss completes packet");

    irq_en = 1'b0;
    wr(16'h3C01, 4'b0001, 16'h3D03, "R10 commit with interrupts off");
    step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 16'h3C00, "R10 no interrupt when disabled");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule